// File: doc/BRIEF.md
# Storage Barrier Ordering Controller

This block sits between an in-order issue stage and a memory request port. Every cycle the issue stage may present one tagged operation: a load, a store, a non-storage operation, a light (storage-only) barrier or a full (synchronizing) barrier. Loads and stores are forwarded to memory over a valid/ready request channel. The memory side reports each performed access with a single-cycle acknowledge pulse, and acknowledges arrive in request order. The block counts accesses that have been requested but not yet acknowledged, and it uses that count to decide when each barrier is satisfied.

A light barrier fences storage accesses only. Later loads and stores may not reach memory until every earlier access has been acknowledged, but non-storage operations keep flowing. To keep issue moving, one later storage operation can be parked in a holding slot. A full barrier also waits for every earlier access to be acknowledged, including a parked one, and it stops every later operation of any kind until then. A configuration input makes light barriers behave as full barriers. A barrier that meets an idle memory side costs no cycles.

Top module: `mem_order_ctrl`

## Requirements
- R1: After reset no access is outstanding, no barrier is pending and the holding slot is empty. `mreq_valid` is low, and the first operation presented is accepted without a stall.
- R2: Operation codes on `issue_kind` are load=0, store=1, non-storage=2 (codes 5 to 7 also act as non-storage), light barrier=3 and full barrier=4. Outside a barrier window a load or store is driven straight onto the request channel (`mreq_write` is 1 for a store and 0 for a load, with its address and data). It is accepted in the same cycle as the request handshake. Each handshake stays outstanding until one `mack_valid` pulse, and pulses retire requests in order.
- R3: No more than `MAX_OUT` accesses are ever outstanding. While that many are outstanding, `mreq_valid` stays low.
- R4: After a light barrier is accepted, no load or store that follows it in program order is requested until every storage access accepted before the barrier has been acknowledged.
- R5: A pending light barrier never stalls a non-storage operation.
- R6: While a light barrier is blocking, the first later load or store is accepted into the holding slot without a stall. A further load or store is stalled for as long as the slot is occupied.
- R7: After a full barrier is accepted, no later operation of any kind is accepted until every storage access accepted before the barrier, including one in the holding slot, has been acknowledged.
- R8: With `cfg_light_as_full` high, a light barrier behaves exactly like a full barrier. In particular, non-storage operations after it stall while earlier accesses are outstanding.
- R9: A barrier presented while nothing is outstanding and the holding slot is empty is accepted in that cycle. An operation presented in the next cycle is not stalled on its account.
- R10: A light barrier presented while the holding slot is occupied is stalled until the parked access has been requested. This keeps accesses after the second barrier from reaching memory before the parked one has been performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_light_as_full | input | 1 | When high, light barriers are handled as full barriers |
| issue_valid | input | 1 | An operation is presented |
| issue_kind | input | 3 | Operation code (see R2) |
| issue_addr | input | AW | Access address for loads and stores |
| issue_wdata | input | DW | Store data |
| issue_ready | output | 1 | The presented operation is accepted this cycle |
| mreq_valid | output | 1 | Memory request valid |
| mreq_write | output | 1 | 1 for a store, 0 for a load |
| mreq_addr | output | AW | Request address |
| mreq_wdata | output | DW | Request store data |
| mreq_ready | input | 1 | Memory side takes the request this cycle |
| mack_valid | input | 1 | One earlier request has been performed |

## Verification
The bench builds the block with `MAX_OUT` = 3 and 16-bit address and data. A short burst of stores therefore reaches the outstanding limit, and the counter variant (not the single-flag one) is exercised. Acknowledge latencies of up to ten cycles keep barriers pending long enough for a light barrier, a parked access, a second stalled access and a following barrier to meet in the same window. An unconstrained mix with a stuttering ready then drives the mode input both ways.

// File: rtl/mbo_pkg.sv
package mbo_pkg;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_OTHER = 3'd2,
      OP_LBAR  = 3'd3,
      OP_FBAR  = 3'd4
   } mbo_op_e;

   function automatic logic op_is_access(input logic [2:0] k);
      return (k == OP_LOAD) || (k == OP_STORE);
   endfunction

   function automatic logic op_is_store(input logic [2:0] k);
      return k == OP_STORE;
   endfunction

endpackage

// File: rtl/mbo_out_counter.sv
module mbo_out_counter #(
   parameter int MAX_OUT = 4,
   localparam int CW = $clog2(MAX_OUT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          cnt_zero,
   output logic          cnt_full
);

   if (MAX_OUT < 1) begin : g_bad_depth
      $error("mbo_out_counter: MAX_OUT must be at least 1");
   end

   if (MAX_OUT == 1) begin : g_flag
      logic busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
         end else if (inc) begin
            busy_q <= 1'b1;
         end else if (dec) begin
            busy_q <= 1'b0;
         end
      end
      assign cnt = CW'(busy_q);
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(inc) - CW'(dec);
         end
      end
      assign cnt = cnt_q;
   end

   assign cnt_zero = (cnt == '0);
   assign cnt_full = (cnt == CW'(MAX_OUT));

endmodule

// File: rtl/mbo_hold_slot.sv
module mbo_hold_slot #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          park,
   input  logic          park_wr,
   input  logic [AW-1:0] park_addr,
   input  logic [DW-1:0] park_data,
   input  logic          launch,
   output logic          slot_vld,
   output logic          slot_wr,
   output logic [AW-1:0] slot_addr,
   output logic [DW-1:0] slot_data
);

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("mbo_hold_slot: widths must be positive");
   end

   logic vld_q;
   logic wr_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else if (park) begin
         vld_q <= 1'b1;
      end else if (launch) begin
         vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (park) begin
         wr_q   <= park_wr;
         addr_q <= park_addr;
         data_q <= park_data;
      end
   end

   assign slot_vld  = vld_q;
   assign slot_wr   = wr_q;
   assign slot_addr = addr_q;
   assign slot_data = data_q;

endmodule

// File: rtl/mbo_barrier_track.sv
module mbo_barrier_track (
   input  logic clk,
   input  logic rst_n,
   input  logic take_light,
   input  logic take_full,
   input  logic drained,
   input  logic slot_vld,
   output logic light_pend,
   output logic full_pend,
   output logic light_blk,
   output logic full_blk
);

   logic lp_q;
   logic fp_q;
   logic lp_d;
   logic fp_d;

   always_comb begin
      lp_d = (lp_q | take_light) & ~drained;
      fp_d = (fp_q | take_full) & (~drained | slot_vld);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lp_q <= 1'b0;
         fp_q <= 1'b0;
      end else begin
         lp_q <= lp_d;
         fp_q <= fp_d;
      end
   end

   assign light_pend = lp_q;
   assign full_pend  = fp_q;
   assign light_blk  = lp_q & ~drained;
   assign full_blk   = fp_q & (~drained | slot_vld);

endmodule

// File: rtl/mem_order_ctrl.sv
module mem_order_ctrl
   import mbo_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int MAX_OUT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_light_as_full,
   input  logic          issue_valid,
   input  logic [2:0]    issue_kind,
   input  logic [AW-1:0] issue_addr,
   input  logic [DW-1:0] issue_wdata,
   output logic          issue_ready,
   output logic          mreq_valid,
   output logic          mreq_write,
   output logic [AW-1:0] mreq_addr,
   output logic [DW-1:0] mreq_wdata,
   input  logic          mreq_ready,
   input  logic          mack_valid
);

   localparam int CW = $clog2(MAX_OUT + 1);

   if (MAX_OUT < 1) begin : g_bad_limit
      $error("mem_order_ctrl: MAX_OUT must be at least 1");
   end

   logic [CW-1:0] out_cnt;
   logic          cnt_zero;
   logic          cnt_full;
   logic          light_pend;
   logic          full_pend;
   logic          light_blk;
   logic          full_blk;
   logic          slot_vld;
   logic          slot_wr;
   logic [AW-1:0] slot_addr;
   logic [DW-1:0] slot_data;

   logic kind_access;
   logic kind_light;
   logic kind_full;
   logic pres_access;
   logic direct_path;
   logic slot_go;
   logic req_fire;
   logic accept;
   logic park;

   always_comb begin
      kind_access = op_is_access(issue_kind);
      kind_light  = (issue_kind == OP_LBAR) & ~cfg_light_as_full;
      kind_full   = (issue_kind == OP_FBAR) |
                    ((issue_kind == OP_LBAR) & cfg_light_as_full);
      pres_access = issue_valid & kind_access;
      direct_path = ~slot_vld & ~light_blk & ~full_blk;
      slot_go     = slot_vld & ~light_blk & ~cnt_full;
   end

   always_comb begin
      if (full_blk) begin
         issue_ready = 1'b0;
      end else if (kind_access) begin
         if (slot_vld) begin
            issue_ready = 1'b0;
         end else if (light_blk) begin
            issue_ready = 1'b1;
         end else begin
            issue_ready = mreq_ready & ~cnt_full;
         end
      end else if (kind_light) begin
         issue_ready = ~slot_vld;
      end else begin
         issue_ready = 1'b1;
      end
   end

   always_comb begin
      if (slot_vld) begin
         mreq_valid = slot_go;
         mreq_write = slot_wr;
         mreq_addr  = slot_addr;
         mreq_wdata = slot_data;
      end else begin
         mreq_valid = pres_access & direct_path & ~cnt_full;
         mreq_write = op_is_store(issue_kind);
         mreq_addr  = issue_addr;
         mreq_wdata = issue_wdata;
      end
   end

   assign req_fire = mreq_valid & mreq_ready;
   assign accept   = issue_valid & issue_ready;
   assign park     = accept & kind_access & ~slot_vld & light_blk;

   mbo_out_counter #(
      .MAX_OUT (MAX_OUT)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (req_fire),
      .dec      (mack_valid),
      .cnt      (out_cnt),
      .cnt_zero (cnt_zero),
      .cnt_full (cnt_full)
   );

   mbo_hold_slot #(
      .AW (AW),
      .DW (DW)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .park      (park),
      .park_wr   (op_is_store(issue_kind)),
      .park_addr (issue_addr),
      .park_data (issue_wdata),
      .launch    (slot_go & mreq_ready),
      .slot_vld  (slot_vld),
      .slot_wr   (slot_wr),
      .slot_addr (slot_addr),
      .slot_data (slot_data)
   );

   mbo_barrier_track u_bar (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_light (accept & kind_light),
      .take_full  (accept & kind_full),
      .drained    (cnt_zero),
      .slot_vld   (slot_vld),
      .light_pend (light_pend),
      .full_pend  (full_pend),
      .light_blk  (light_blk),
      .full_blk   (full_blk)
   );

endmodule

// File: rtl/mem_order_chk.sv
module mem_order_chk
   import mbo_pkg::*;
#(
   parameter int MAX_OUT = 4,
   localparam int CW = $clog2(MAX_OUT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_light_as_full,
   input logic          issue_valid,
   input logic [2:0]    issue_kind,
   input logic          issue_ready,
   input logic          mreq_valid,
   input logic [CW-1:0] cnt,
   input logic          lpend,
   input logic          fpend,
   input logic          slot_vld
);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAX_OUT)); // R3

   AST_NO_REQ_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == CW'(MAX_OUT) |-> !mreq_valid); // R3

   AST_LIGHT_GATES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lpend && cnt != '0 |-> !mreq_valid); // R4

   AST_LIGHT_PASSES_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_kind == OP_OTHER && !fpend |-> issue_ready); // R5

   AST_SLOT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld && issue_valid && op_is_access(issue_kind) |-> !issue_ready); // R6

   AST_FULL_STALLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      fpend && cnt != '0 |-> !issue_ready); // R7

   AST_MODE_NO_LIGHT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_light_as_full && !lpend |=> !lpend); // R8

   AST_IDLE_BARRIER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && (issue_kind == OP_LBAR || issue_kind == OP_FBAR) &&
      cnt == '0 && !slot_vld |-> issue_ready); // R9

   AST_LIGHT_WAITS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld && issue_valid && issue_kind == OP_LBAR && !cfg_light_as_full
      |-> !issue_ready); // R10

endmodule

bind mem_order_ctrl mem_order_chk #(
   .MAX_OUT (MAX_OUT)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .cfg_light_as_full (cfg_light_as_full),
   .issue_valid       (issue_valid),
   .issue_kind        (issue_kind),
   .issue_ready       (issue_ready),
   .mreq_valid        (mreq_valid),
   .cnt               (out_cnt),
   .lpend             (light_pend),
   .fpend             (full_pend),
   .slot_vld          (slot_vld)
);

// File: tb/mem_order_ctrl_tb_top.sv
`timescale 1ns/1ps
module mem_order_ctrl_tb_top;

   localparam int AW   = 16;
   localparam int DW   = 16;
   localparam int MAXO = 3;
   localparam int WD   = 60000;

   typedef struct {
      logic [2:0]  k;
      logic [15:0] a;
      logic [15:0] d;
   } op_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg = 1'b0;
   logic          iv = 1'b0;
   logic [2:0]    ik = 3'd2;
   logic [AW-1:0] ia = '0;
   logic [DW-1:0] id = '0;
   logic          ir;
   logic          mv;
   logic          mw;
   logic [AW-1:0] ma;
   logic [DW-1:0] md;
   logic          mr = 1'b1;
   logic          mk = 1'b0;

   always #2 clk = ~clk;

   mem_order_ctrl #(.AW(AW), .DW(DW), .MAX_OUT(MAXO)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_light_as_full(cfg),
      .issue_valid(iv), .issue_kind(ik), .issue_addr(ia), .issue_wdata(id),
      .issue_ready(ir), .mreq_valid(mv), .mreq_write(mw), .mreq_addr(ma),
      .mreq_wdata(md), .mreq_ready(mr), .mack_valid(mk));

   op_t prog[$];
   int  due[$];
   int  nchk = 0, nerr = 0, cyc = 0;
   int  n_req = 0, n_ack = 0, n_mem = 0, n_ops = 0;
   int  lb_need = 0, fb_need = 0, fb_idx = -1, last_due = 0;
   bit  fb_by_mode = 0, done = 0;
   bit  cfg_sel = 0, rdy_rand = 0, lat_rand = 0;
   int  lat_fix = 3;
   bit  m_lb = 0, m_fb = 0, m_hold = 0, mh_wr = 0;
   logic [15:0] mh_a = '0, mh_d = '0;

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", rq, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      int  mc, lat;
      bit  isl, kl, kf, fbb, lbb, fl, hgo, e_mv, e_rdy, acc, req, e_wr;
      logic [15:0] e_a, e_d;
      cyc++;
      if (cyc > WD) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD);
         finish_run();
      end
      if (!rst_n) begin
         iv = 0; mk = 0; mr = 1;
      end else begin
         cfg = cfg_sel;
         iv  = prog.size() > 0;
         if (iv) begin ik = prog[0].k; ia = prog[0].a; id = prog[0].d; end
         else begin ik = 3'd2; end
         mr = rdy_rand ? (($urandom % 10) < 7) : 1'b1;
         mk = due.size() > 0 && due[0] <= cyc;
         #1;
         mc  = n_req - n_ack;
         isl = iv && (ik == 3'd0 || ik == 3'd1);
         kl  = ik == 3'd3 && !cfg;
         kf  = ik == 3'd4 || (ik == 3'd3 && cfg);
         fbb = m_fb && (mc != 0 || m_hold);
         lbb = m_lb && mc != 0;
         fl  = mc == MAXO;
         hgo = m_hold && !lbb && !fl;
         e_mv = hgo || (isl && !m_hold && !lbb && !fbb && !fl);
         e_wr = m_hold ? mh_wr : (ik == 3'd1);
         e_a  = m_hold ? mh_a : ia;
         e_d  = m_hold ? mh_d : id;
         if (fbb) e_rdy = 0;
         else if (ik == 3'd0 || ik == 3'd1) e_rdy = m_hold ? 0 : (lbb ? 1 : (mr && !fl));
         else if (kl) e_rdy = !m_hold;
         else e_rdy = 1;
         // R2: request channel follows the expected source
         chk(mv == e_mv, "R2 mreq_valid", mv, e_mv);
         if (e_mv && mv) begin
            chk(mw == e_wr, "R2 mreq_write", mw, e_wr);
            chk(ma == e_a, "R2 mreq_addr", ma, e_a);
            chk(md == e_d, "R2 mreq_wdata", md, e_d);
         end
         if (iv) begin
            if (ik == 3'd0 || ik == 3'd1) chk(ir == e_rdy, "R6 ready(access)", ir, e_rdy);
            else if (ik == 3'd3) chk(ir == e_rdy, cfg ? "R8 ready(light as full)" : "R10 ready(light)", ir, e_rdy);
            else if (ik == 3'd4) chk(ir == e_rdy, "R9 ready(full)", ir, e_rdy);
            else chk(ir == e_rdy, "R5 ready(other)", ir, e_rdy);
         end
         acc = iv && ir;
         req = mv && mr;
         // R3: outstanding limit
         chk(mc <= MAXO, "R3 outstanding bound", mc, MAXO);
         if (mc == MAXO) chk(!mv, "R3 no request at limit", mv, 0);
         // R4: later access must wait for acks of earlier ones
         if (req && n_req >= lb_need) chk(n_ack >= lb_need, "R4 light barrier order", n_ack, lb_need);
         // R7 / R8: nothing passes a full barrier early
         if (acc && n_ops > fb_idx)
            chk(n_ack >= fb_need, fb_by_mode ? "R8 mode full order" : "R7 full barrier order", n_ack, fb_need);
         // model update
         if (req) begin
            lat = lat_rand ? 1 + int'($urandom % 8) : lat_fix;
            last_due = (cyc + lat > last_due) ? cyc + lat : last_due;
            due.push_back(last_due);
         end
         if (mk) void'(due.pop_front());
         if (acc) begin
            if (kl) lb_need = n_mem;
            if (kf) begin fb_need = n_mem; fb_idx = n_ops; fb_by_mode = (ik == 3'd3); end
            if (isl) n_mem++;
            n_ops++;
            void'(prog.pop_front());
         end
         begin
            bit nl, nf, nh;
            nl = (m_lb || (acc && kl)) && mc != 0;
            nf = (m_fb || (acc && kf)) && (mc != 0 || m_hold);
            nh = m_hold;
            if (hgo && mr) nh = 0;
            if (acc && isl && !m_hold && lbb && !fbb) begin
               nh = 1; mh_wr = (ik == 3'd1); mh_a = ia; mh_d = id;
            end
            m_lb = nl; m_fb = nf; m_hold = nh;
         end
         n_req += int'(req);
         n_ack += int'(mk);
      end
   end

   task automatic put(input logic [2:0] k, input int a, input int d);
      op_t o;
      o.k = k; o.a = 16'(a); o.d = 16'(d);
      prog.push_back(o);
   endtask

   task automatic settle();
      wait (prog.size() == 0 && n_req == n_ack && !m_hold);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      // R1: reset state visible at the ports
      chk(mv == 1'b0, "R1 mreq_valid after reset", mv, 0);
      @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1.5;
      chk(mv == 1'b0, "R1 idle request channel", mv, 0);
      // R9: idle barriers, then traffic right after
      put(3'd4, 0, 0); put(3'd0, 16'h10, 0); put(3'd2, 0, 0);
      settle();
      put(3'd3, 0, 0); put(3'd1, 16'h20, 16'hA5);
      settle();
      // R4 R5 R6: store, light barrier, load parked, others flow, second access stalls
      lat_fix = 6;
      put(3'd1, 16'h100, 16'h1111); put(3'd3, 0, 0); put(3'd0, 16'h200, 0);
      put(3'd2, 0, 0); put(3'd2, 0, 0); put(3'd1, 16'h300, 16'h3333);
      settle();
      // R3: burst above the outstanding limit
      lat_fix = 10;
      for (int i = 0; i < 6; i++) put(3'd1, 16'h400 + i, i);
      settle();
      // R7: full barrier stalls a non-storage op
      lat_fix = 5;
      put(3'd0, 16'h500, 0); put(3'd4, 0, 0); put(3'd2, 0, 0); put(3'd1, 16'h504, 7);
      settle();
      // R10: light barrier behind a parked access
      put(3'd1, 16'h600, 1); put(3'd3, 0, 0); put(3'd0, 16'h604, 0);
      put(3'd3, 0, 0); put(3'd0, 16'h608, 0);
      settle();
      // R8: mode makes light behave as full
      cfg_sel = 1;
      put(3'd1, 16'h700, 2); put(3'd3, 0, 0); put(3'd2, 0, 0); put(3'd0, 16'h704, 0);
      settle();
      // mixed traffic, both modes
      rdy_rand = 1; lat_rand = 1;
      for (int ph = 0; ph < 2; ph++) begin
         cfg_sel = ph[0];
         for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 16);
            put(r < 5 ? 3'd0 : r < 10 ? 3'd1 : r < 13 ? 3'd2 : r < 15 ? 3'd3 : 3'd4,
                int'($urandom % 65536), int'($urandom % 65536));
         end
         settle();
      end
      finish_run();
   end

endmodule